// File: doc/BRIEF.md
# Memory Slot Selector with Boot Override

This block sits between a Z80-style processor and the memory devices of a 64 KB system that is split into four 16 KB pages. Each page can be mapped to any one of four primary slots. The two top address bits name the page. A byte-wide slot register decides which slot serves that page. The slot register lives in a small model of a parallel peripheral interface. That model has three registers that software writes through I/O ports: the slot byte (port A), a general output port (port C) and a control register. The outputs are four active-low slot selects, one per slot. They are gated so that only real memory cycles reach the devices.

After reset, the interface ports come up as inputs, so the slot register cannot be trusted. A synchronous set/reset override bit is set by reset. While it is set, every page resolves to slot 0, where the boot ROM lives. The boot code then configures the interface and loads the slot byte. Next it drives one designated port C line high, either with a direct byte write or with a single-bit set/reset control word. That event clears the override, and slot selection follows the register from then on. Writes that merely address the interface do not end the override.

The I/O write interface has no back-pressure. A write is accepted on every clock edge where `io_wr` is high. The memory-side inputs are decoded combinationally.

Top module: `slot_selector`

## Requirements
- R1: While the boot override is set (from reset until it is released), every memory access selects slot 0, whatever the page and the slot register hold: `slot_sel_n` = 4'b1110.
- R2: Once the override is released, an access to page n (n = {A15,A14} on `mem_page`) selects the slot coded in slot byte bits [2n+1:2n]. Slot k drives `slot_sel_n[k]` low.
- R3: A control write with bit 7 = 1 is a mode set. It clears the port A and port C registers. Control bit 4 = 1 makes port A an input, and then the slot byte reads as 8'hFF. Control bit 3 = 1 makes the upper half of port C an input, and bit 0 = 1 does the same for the lower half. The word 8'h82 makes both port A and port C outputs.
- R4: A direct write to port C (`io_addr` = 2) that sets bit 2 while the lower half of port C is an output releases the override. The new mapping is in effect after the next clock edge.
- R5: A control write with bit 7 = 0 sets port C bit [3:1] to the value of bit 0. When this drives bit 2 high with the lower half configured as output, it releases the override like R4.
- R6: Writes to port A (`io_addr` = 0) and control (`io_addr` = 3) that leave port C bit 2 undriven or low do not release the override.
- R7: No select is asserted unless `mreq_n` is low and `rfsh_n` is high. A refresh cycle or an idle bus gives `slot_sel_n` = 4'b1111.
- R8: Writes to port B (`io_addr` = 1) have no effect on slot selection.
- R9: Asserting `rst_n` low at any time sets the override again and clears the slot register to 8'h00.
- R10: Setting port C bit 2 while the lower half of port C is configured as input does not release the override.
- R11: At most one slot select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, accepted on each rising edge where high |
| io_addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| io_wdata | input | 8 | I/O write data |
| mem_page | input | 2 | Address bits A15:A14 of the current access |
| mreq_n | input | 1 | Active-low memory request |
| rfsh_n | input | 1 | Active-low refresh cycle indicator |
| slot_sel_n | output | 4 | Active-low slot selects, bit k for slot k |

## Verification
The hardest state to reach is the stretch where the override must hold while the interface is being configured. During that stretch the bus carries chip-select traffic: a mode set, slot byte loads and port B writes. Each probe in that stretch must still show slot 0 on a page whose register field says otherwise. The stimulus fills the slot byte with non-zero fields first, so a premature release shows at once. Releases through the direct port C write and through the bit set/reset word are run on separate reset passes. A pass with the lower half of port C set to input shows that an undriven clearing line never ends the override. After release, a mode set that turns port A into an input checks the 8'hFF read-back.

// File: rtl/slot_pkg.sv
package slot_pkg;

  // I/O register selects on io_addr
  typedef enum logic [1:0] {
    IO_PORT_A = 2'd0,
    IO_PORT_B = 2'd1,
    IO_PORT_C = 2'd2,
    IO_CTRL   = 2'd3
  } io_sel_e;

  localparam int IO_W       = 8;
  localparam int CW_MODE    = 7;  // 1: mode set, 0: port C bit set/reset
  localparam int CW_A_IN    = 4;
  localparam int CW_CHI_IN  = 3;
  localparam int CW_CLO_IN  = 0;

  typedef struct packed {
    logic a_in;
    logic chi_in;
    logic clo_in;
  } port_dir_t;

  localparam port_dir_t DIR_RESET = '{a_in: 1'b1, chi_in: 1'b1, clo_in: 1'b1};

endpackage

// File: rtl/slot_ppi_regs.sv
module slot_ppi_regs
  import slot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_wr,
  input  logic [1:0]      io_addr,
  input  logic [IO_W-1:0] io_wdata,
  output logic [IO_W-1:0] slot_byte,
  output logic [IO_W-1:0] pc_pins
);

  localparam int HALF = IO_W / 2;

  logic [IO_W-1:0] pa_q;
  logic [IO_W-1:0] pc_q;
  port_dir_t       dir_q;
  io_sel_e         sel;

  assign sel = io_sel_e'(io_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      pc_q  <= '0;
      dir_q <= DIR_RESET;
    end else if (io_wr) begin
      unique case (sel)
        IO_PORT_A: pa_q <= io_wdata;
        IO_PORT_C: pc_q <= io_wdata;
        IO_CTRL: begin
          if (io_wdata[CW_MODE]) begin
            dir_q <= '{a_in:   io_wdata[CW_A_IN],
                       chi_in: io_wdata[CW_CHI_IN],
                       clo_in: io_wdata[CW_CLO_IN]};
            pa_q  <= '0;
            pc_q  <= '0;
          end else begin
            pc_q[io_wdata[3:1]] <= io_wdata[0];
          end
        end
        default: ;  // port B carries nothing this block uses
      endcase
    end
  end

  // An input-mode port A floats high through pull-ups.
  assign slot_byte = dir_q.a_in ? '1 : pa_q;
  // Port C lines only drive when their half is an output.
  assign pc_pins   = pc_q & {{HALF{~dir_q.chi_in}}, {HALF{~dir_q.clo_in}}};

endmodule

// File: rtl/boot_latch.sv
module boot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic boot_ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   boot_ovr <= 1'b1;
    else if (clr) boot_ovr <= 1'b0;
  end

endmodule

// File: rtl/slot_decode.sv
module slot_decode #(
  parameter int NUM_PAGES = 4,
  parameter int SLOT_BITS = 2
) (
  input  logic [NUM_PAGES*SLOT_BITS-1:0] slot_byte,
  input  logic [$clog2(NUM_PAGES)-1:0]   page,
  input  logic                           boot_ovr,
  input  logic                           mreq_n,
  input  logic                           rfsh_n,
  output logic [(1<<SLOT_BITS)-1:0]      sel_n
);

  localparam int NUM_SLOTS = 1 << SLOT_BITS;
  localparam int PAGE_W    = $clog2(NUM_PAGES);

  logic [SLOT_BITS-1:0] code;
  logic                 access;

  always_comb begin
    code = '0;
    if (!boot_ovr) begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (page == PAGE_W'(p)) code = slot_byte[p*SLOT_BITS +: SLOT_BITS];
      end
    end
  end

  assign access = !mreq_n && rfsh_n;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    assign sel_n[s] = !(access && (code == SLOT_BITS'(s)));
  end

endmodule

// File: rtl/slot_selector.sv
module slot_selector
  import slot_pkg::*;
#(
  parameter int CLR_BIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [1:0]  io_addr,
  input  logic [7:0]  io_wdata,
  input  logic [1:0]  mem_page,
  input  logic        mreq_n,
  input  logic        rfsh_n,
  output logic [3:0]  slot_sel_n
);

  localparam int NUM_PAGES = 4;
  localparam int SLOT_BITS = IO_W / NUM_PAGES;

  logic [IO_W-1:0] slot_byte;
  logic [IO_W-1:0] pc_pins;
  logic            clr_line;
  logic            boot_ovr;

  slot_ppi_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .slot_byte (slot_byte),
    .pc_pins   (pc_pins)
  );

  assign clr_line = pc_pins[CLR_BIT];

  boot_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_line),
    .boot_ovr (boot_ovr)
  );

  slot_decode #(
    .NUM_PAGES (NUM_PAGES),
    .SLOT_BITS (SLOT_BITS)
  ) u_dec (
    .slot_byte (slot_byte),
    .page      (mem_page),
    .boot_ovr  (boot_ovr),
    .mreq_n    (mreq_n),
    .rfsh_n    (rfsh_n),
    .sel_n     (slot_sel_n)
  );

endmodule

// File: rtl/slot_selector_chk.sv
module slot_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic [1:0] io_addr,
  input logic       mreq_n,
  input logic       rfsh_n,
  input logic [3:0] slot_sel_n,
  input logic [7:0] slot_byte,
  input logic       clr_line,
  input logic       boot_ovr
);

  AST_BOOT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_ovr && !mreq_n && rfsh_n) |-> (slot_sel_n == 4'b1110)); // R1

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_line |=> !boot_ovr); // R4

  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_ovr && !clr_line) |=> boot_ovr); // R6

  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (&slot_sel_n)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (&slot_sel_n)); // R7

  AST_PORTB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd1) |=> $stable(slot_byte)); // R8

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~slot_sel_n) <= 1); // R11

endmodule

bind slot_selector slot_selector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_wr      (io_wr),
  .io_addr    (io_addr),
  .mreq_n     (mreq_n),
  .rfsh_n     (rfsh_n),
  .slot_sel_n (slot_sel_n),
  .slot_byte  (slot_byte),
  .clr_line   (clr_line),
  .boot_ovr   (boot_ovr)
);

// File: tb/tb_slot_selector.sv
`timescale 1ns/1ps
module tb_slot_selector;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic [1:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [1:0] mem_page = '0;
  logic       mreq_n = 1'b1;
  logic       rfsh_n = 1'b1;
  logic [3:0] slot_sel_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  slot_selector dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mem_page(mem_page), .mreq_n(mreq_n),
    .rfsh_n(rfsh_n), .slot_sel_n(slot_sel_n)
  );

  // Row layout: [21:18] requirement, [17:16] op (0 write, 1 probe),
  // [15:14] io_addr or page, [13:6] data, [5] mreq_n, [4] rfsh_n, [3:0] expected sel
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,  2'd1, 2'd0, 8'h00, 1'b0, 1'b1, 4'b1110},  // R1 page 0 after reset
    {4'd1,  2'd1, 2'd3, 8'h00, 1'b0, 1'b1, 4'b1110},  // R1 page 3 after reset
    {4'd6,  2'd0, 2'd0, 8'hE4, 1'b1, 1'b1, 4'b1111},  // load port A
    {4'd6,  2'd1, 2'd1, 8'h00, 1'b0, 1'b1, 4'b1110},  // R6 still slot 0
    {4'd6,  2'd0, 2'd3, 8'h82, 1'b1, 1'b1, 4'b1111},  // mode set
    {4'd6,  2'd1, 2'd2, 8'h00, 1'b0, 1'b1, 4'b1110},  // R6 after mode set
    {4'd6,  2'd0, 2'd0, 8'hE4, 1'b1, 1'b1, 4'b1111},  // slots 3,2,1,0
    {4'd6,  2'd1, 2'd3, 8'h00, 1'b0, 1'b1, 4'b1110},  // R6 after slot load
    {4'd8,  2'd0, 2'd1, 8'hFF, 1'b1, 1'b1, 4'b1111},  // port B write
    {4'd8,  2'd1, 2'd3, 8'h00, 1'b0, 1'b1, 4'b1110},  // R8 no release
    {4'd4,  2'd0, 2'd2, 8'h04, 1'b1, 1'b1, 4'b1111},  // port C bit 2 high
    {4'd4,  2'd1, 2'd3, 8'h00, 1'b0, 1'b1, 4'b0111},  // R4 released, page 3
    {4'd2,  2'd1, 2'd0, 8'h00, 1'b0, 1'b1, 4'b1110},  // R2 page 0
    {4'd2,  2'd1, 2'd1, 8'h00, 1'b0, 1'b1, 4'b1101},  // R2 page 1
    {4'd2,  2'd1, 2'd2, 8'h00, 1'b0, 1'b1, 4'b1011},  // R2 page 2
    {4'd7,  2'd1, 2'd2, 8'h00, 1'b0, 1'b0, 4'b1111},  // R7 refresh
    {4'd7,  2'd1, 2'd2, 8'h00, 1'b1, 1'b1, 4'b1111},  // R7 idle
    {4'd8,  2'd0, 2'd1, 8'h00, 1'b1, 1'b1, 4'b1111},  // port B write
    {4'd8,  2'd1, 2'd1, 8'h00, 1'b0, 1'b1, 4'b1101},  // R8 mapping kept
    {4'd3,  2'd0, 2'd3, 8'h92, 1'b1, 1'b1, 4'b1111},  // port A to input
    {4'd3,  2'd1, 2'd0, 8'h00, 1'b0, 1'b1, 4'b0111},  // R3 reads FF
    {4'd3,  2'd1, 2'd1, 8'h00, 1'b0, 1'b1, 4'b0111}   // R3 reads FF
  };

  task automatic check(input int req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: slot_sel_n=%b expected %b", req, got, exp);
    end
    checks++;
    if ($countones(~got) > 1) begin  // R11
      errors++;
      $display("FAIL R11: slot_sel_n=%b expected at most one low", got);
    end
  endtask

  task automatic io_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic probe(input int req, input logic [1:0] pg, input logic m,
                       input logic r, input logic [3:0] exp);
    @(negedge clk);
    mem_page = pg; mreq_n = m; rfsh_n = r;
    @(posedge clk);
    @(negedge clk);
    check(req, slot_sel_n, exp);
    mreq_n = 1'b1; rfsh_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state, idle bus: no select
    @(negedge clk);
    check(9, slot_sel_n, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17:16] == 2'd0)
        io_write(VEC[i][15:14], VEC[i][13:6]);
      else
        probe(int'(VEC[i][21:18]), VEC[i][15:14], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    // R9: reset re-arms the override after release
    do_reset();
    probe(9, 2'd3, 1'b0, 1'b1, 4'b1110);
    io_write(2'd3, 8'h82);  // port A stays 00 after reset: R9 register cleared
    io_write(2'd3, 8'h05);  // R5 bit set/reset: bit 2 <- 1
    probe(9, 2'd3, 1'b0, 1'b1, 4'b1110);  // R9 slot byte is 00
    io_write(2'd0, 8'hFF);
    probe(5, 2'd1, 1'b0, 1'b1, 4'b0111);  // R5 released via bit set

    // R10: lower half of port C as input, clearing line undriven
    do_reset();
    io_write(2'd3, 8'h83);
    io_write(2'd0, 8'hFF);
    io_write(2'd2, 8'hFF);
    probe(10, 2'd2, 1'b0, 1'b1, 4'b1110);
    io_write(2'd3, 8'h05);
    probe(10, 2'd0, 1'b0, 1'b1, 4'b1110);
    // reconfigure as output, then release through bit set/reset (R5)
    io_write(2'd3, 8'h82);
    io_write(2'd0, 8'h1B);  // pages 0..3 -> slots 3,2,1,0
    probe(6, 2'd0, 1'b0, 1'b1, 4'b1110);
    io_write(2'd3, 8'h05);
    probe(5, 2'd0, 1'b0, 1'b1, 4'b0111);
    probe(2, 2'd3, 1'b0, 1'b1, 4'b1110);
    // R5: clearing bit 2 afterwards does not bring the override back
    io_write(2'd3, 8'h04);
    probe(5, 2'd1, 1'b0, 1'b1, 4'b1011);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule